// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a distributed shared memory machine and keeps one directory entry per memory block. Each entry holds a coarse state (uncached, shared by readers, or held exclusively by one writer) and a full presence vector with one bit per node. Requesting caches send read misses, write misses and writebacks. The controller answers each miss with a data reply after it has removed or downgraded any conflicting copies elsewhere.

To remove copies it sends invalidations to readers. To reach an exclusive holder it sends a fetch, which downgrades the holder, or a fetch-and-invalidate, which evicts it. It then counts acknowledgements until every one is back. Only then is the data reply released and the entry rewritten. One transaction is open at a time, so the request port stalls until it retires. Message transport, the caches and the memory array lie outside the block.

Top module: `dir_ctrl`

## Requirements
- R1: A read (request op 0) to an uncached or shared block produces exactly one DATA message (message op 0) to the requester. Afterwards the block is shared and the requester is added to its presence vector.
- R2: A write (request op 1) to an uncached block produces exactly one DATA reply to the requester. Afterwards the block is exclusive with the requester as sole holder.
- R3: A write to a shared block sends one INV message (op 1) to every present node other than the requester, in ascending node order, and then sends DATA. Afterwards the requester is the exclusive holder.
- R4: A read to an exclusive block sends FETCH (op 2) to the holder and then DATA. Afterwards the block is shared by the old holder and the requester.
- R5: A write to an exclusive block sends FETCH_INV (op 3) to the old holder, then DATA. Afterwards the requester is the only holder. An exclusive entry always has exactly one presence bit set.
- R6: A writeback (request op 2) from the exclusive holder makes the block uncached with an empty presence vector and sends no message. A writeback from any other node, or to a non-exclusive block, sends no message and leaves the entry unchanged.
- R7: The DATA reply is not offered until one acknowledgement has arrived for each INV, FETCH or FETCH_INV sent. An acknowledgement arriving in the same cycle as another message handshake is counted.
- R8: While a transaction is open, `req_ready_o` is low for every block and no request is taken.
- R9: A message offered while `msg_ready_i` is low stays valid, with destination, op and block unchanged, until it is taken.
- R10: The requester never receives INV, FETCH or FETCH_INV. A write by the exclusive holder, or by the only reader, is answered with DATA alone.
- R11: After reset `req_ready_o` is high, no message is offered, and every block is uncached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request taken this cycle when valid |
| req_op_i | input | 2 | 0 read miss, 1 write miss, 2 writeback |
| req_node_i | input | NW | Requesting node |
| req_blk_i | input | BW | Block index |
| ack_valid_i | input | 1 | One acknowledgement of an INV/FETCH/FETCH_INV |
| msg_valid_o | output | 1 | Outgoing message offered |
| msg_ready_i | input | 1 | Outgoing message taken |
| msg_op_o | output | 2 | 0 DATA, 1 INV, 2 FETCH, 3 FETCH_INV |
| msg_node_o | output | NW | Destination node |
| msg_blk_o | output | BW | Block index |

## Verification
Two events can fall in the same cycle: the handshake of one invalidation and the acknowledgement of an earlier one. The bench provokes this by returning each acknowledgement in the cycle in which the matching message is taken. The reply must then follow only once the count drains. In a second mode the acknowledgements are held back. The bench then checks for several cycles that no reply appears and the request port stays closed, and releases the acknowledgements one per cycle. A long mixed sweep over all nodes, blocks and operations is judged against a presence-vector model kept in the bench, and sometimes holds off the reply to test its stability.

// File: rtl/dirc_pkg.sv
package dirc_pkg;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_WB = 2'd2} req_op_e;
  typedef enum logic [1:0] {M_DATA = 2'd0, M_INV = 2'd1, M_FETCH = 2'd2, M_FINV = 2'd3} msg_op_e;
  typedef enum logic [1:0] {E_UNC = 2'd0, E_SHD = 2'd1, E_EXC = 2'd2} ent_st_e;
  typedef enum logic [1:0] {F_IDLE = 2'd0, F_COLLECT = 2'd1, F_REPLY = 2'd2} fsm_e;
endpackage

// File: rtl/dir_store.sv
module dir_store import dirc_pkg::*; #(
  parameter int NODES  = 4,
  parameter int BLOCKS = 4,
  localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BW-1:0]    blk_i,
  output ent_st_e          st_o,
  output logic [NODES-1:0] sh_o,
  input  logic             we_i,
  input  ent_st_e          st_i,
  input  logic [NODES-1:0] sh_i
);
  ent_st_e          st_q [BLOCKS];
  logic [NODES-1:0] sh_q [BLOCKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < BLOCKS; b++) begin
        st_q[b] <= E_UNC;
        sh_q[b] <= '0;
      end
    end else if (we_i) begin
      for (int b = 0; b < BLOCKS; b++) begin
        if (blk_i == BW'(b)) begin
          st_q[b] <= st_i;
          sh_q[b] <= sh_i;
        end
      end
    end
  end

  assign st_o = st_q[blk_i];
  assign sh_o = sh_q[blk_i];
endmodule

// File: rtl/dir_pick.sv
module dir_pick #(
  parameter int N = 4,
  localparam int NW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic [NW-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = NW'(i);
    end
  end
endmodule

// File: rtl/dir_ack_ctr.sv
module dir_ack_ctr #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (load_i)                cnt_o <= load_val_i;
    else if (dec_i && cnt_o != '0)  cnt_o <= cnt_o - CW'(1);
  end
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl import dirc_pkg::*; #(
  parameter int NODES  = 4,
  parameter int BLOCKS = 4,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
  localparam int CW = $clog2(NODES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [NW-1:0] req_node_i,
  input  logic [BW-1:0] req_blk_i,
  input  logic          ack_valid_i,
  output logic          msg_valid_o,
  input  logic          msg_ready_i,
  output logic [1:0]    msg_op_o,
  output logic [NW-1:0] msg_node_o,
  output logic [BW-1:0] msg_blk_o
);
  fsm_e             fsm_q;
  req_op_e          op_q;
  msg_op_e          mop_q, mop_nx;
  logic [NW-1:0]    node_q, pick_idx;
  logic [BW-1:0]    blk_q, rd_blk;
  logic [NODES-1:0] tgt_q, tgt_nx, rd_sh, req_oh, node_oh_q, wr_sh;
  logic [CW-1:0]    ack_cnt, tgt_cnt;
  ent_st_e          rd_st, wr_st;
  logic             accept, is_rw, st_we, msg_hs;

  assign req_ready_o = (fsm_q == F_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign is_rw       = (req_op_i == OP_RD) || (req_op_i == OP_WR);
  assign rd_blk      = req_ready_o ? req_blk_i : blk_q;
  assign req_oh      = NODES'(1) << req_node_i;
  assign node_oh_q   = NODES'(1) << node_q;
  assign msg_hs      = msg_valid_o && msg_ready_i;

  dir_store #(.NODES(NODES), .BLOCKS(BLOCKS)) u_store (
    .clk_i, .rst_ni, .blk_i(rd_blk), .st_o(rd_st), .sh_o(rd_sh),
    .we_i(st_we), .st_i(wr_st), .sh_i(wr_sh)
  );

  dir_pick #(.N(NODES)) u_pick (.vec_i(tgt_q), .idx_o(pick_idx));

  dir_ack_ctr #(.CW(CW)) u_ack (
    .clk_i, .rst_ni, .load_i(accept && is_rw), .load_val_i(tgt_cnt),
    .dec_i(ack_valid_i), .cnt_o(ack_cnt)
  );

  // copies to remove or downgrade, requester excluded
  always_comb begin
    tgt_nx = '0;
    mop_nx = M_INV;
    if (rd_st == E_EXC && is_rw) begin
      tgt_nx = rd_sh & ~req_oh;
      mop_nx = (req_op_i == OP_RD) ? M_FETCH : M_FINV;
    end else if (rd_st == E_SHD && req_op_i == OP_WR) begin
      tgt_nx = rd_sh & ~req_oh;
    end
    tgt_cnt = '0;
    for (int i = 0; i < NODES; i++) tgt_cnt = tgt_cnt + CW'(tgt_nx[i]);
  end

  always_comb begin
    st_we = 1'b0;
    wr_st = E_UNC;
    wr_sh = '0;
    if (accept && req_op_i == OP_WB && rd_st == E_EXC && rd_sh[req_node_i]) begin
      st_we = 1'b1;
    end else if (fsm_q == F_REPLY && msg_ready_i) begin
      st_we = 1'b1;
      if (op_q == OP_RD) begin
        wr_st = E_SHD;
        wr_sh = rd_sh | node_oh_q;
      end else begin
        wr_st = E_EXC;
        wr_sh = node_oh_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q  <= F_IDLE;
      op_q   <= OP_RD;
      mop_q  <= M_INV;
      node_q <= '0;
      blk_q  <= '0;
      tgt_q  <= '0;
    end else begin
      unique case (fsm_q)
        F_IDLE: if (accept && is_rw) begin
          op_q   <= req_op_e'(req_op_i);
          mop_q  <= mop_nx;
          node_q <= req_node_i;
          blk_q  <= req_blk_i;
          tgt_q  <= tgt_nx;
          fsm_q  <= (tgt_nx != '0) ? F_COLLECT : F_REPLY;
        end
        F_COLLECT: begin
          if (msg_hs) tgt_q[pick_idx] <= 1'b0;
          if (tgt_q == '0 && ack_cnt == '0) fsm_q <= F_REPLY;
        end
        F_REPLY: if (msg_ready_i) fsm_q <= F_IDLE;
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  always_comb begin
    msg_valid_o = 1'b0;
    msg_op_o    = M_DATA;
    msg_node_o  = node_q;
    msg_blk_o   = blk_q;
    if (fsm_q == F_COLLECT && tgt_q != '0) begin
      msg_valid_o = 1'b1;
      msg_op_o    = mop_q;
      msg_node_o  = pick_idx;
    end else if (fsm_q == F_REPLY) begin
      msg_valid_o = 1'b1;
    end
  end
endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk #(
  parameter int NODES = 4,
  parameter int NW = 2,
  parameter int BW = 2,
  parameter int CW = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             msg_valid_o,
  input logic             msg_ready_i,
  input logic [1:0]       msg_op_o,
  input logic [NW-1:0]    msg_node_o,
  input logic [BW-1:0]    msg_blk_o,
  input logic [NW-1:0]    node_q,
  input logic [CW-1:0]    ack_cnt,
  input logic [1:0]       ent_st,
  input logic [NODES-1:0] ent_sh
);
  // R9
  msg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_op_o)
      && $stable(msg_node_o) && $stable(msg_blk_o));
  // R8
  busy_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> !req_ready_o);
  // R10
  no_self_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_op_o != 2'd0 |-> msg_node_o != node_q);
  // R7
  reply_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_op_o == 2'd0 |-> ack_cnt == '0);
  // R5
  excl_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_st == 2'd2 |-> $onehot(ent_sh));
  // R6
  unc_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_st == 2'd0 |-> ent_sh == '0);
endmodule

bind dir_ctrl dir_ctrl_chk #(.NODES(NODES), .NW(NW), .BW(BW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
  .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i), .msg_op_o(msg_op_o),
  .msg_node_o(msg_node_o), .msg_blk_o(msg_blk_o), .node_q(node_q),
  .ack_cnt(ack_cnt), .ent_st(rd_st), .ent_sh(rd_sh)
);

// File: tb/dir_ctrl_tb.sv
`timescale 1ns/1ps
module dir_ctrl_tb;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       req_valid_i = 1'b0, req_ready_o, ack_valid_i = 1'b0;
  logic [1:0] req_op_i = '0, req_node_i = '0, req_blk_i = '0;
  logic       msg_valid_o, msg_ready_i = 1'b1;
  logic [1:0] msg_op_o, msg_node_o, msg_blk_o;
  int checks = 0, errors = 0;
  int st_m [4];
  logic [3:0] sh_m [4];
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk_i = ~clk_i;

  dir_ctrl #(.NODES(4), .BLOCKS(4)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_msg();
    int w = 0;
    while (!msg_valid_o && w < 20) begin @(negedge clk_i); w++; end
  endtask

  task automatic expect_msg(input int op, input int node, input int blk, input string tag);
    wait_msg();
    chk(msg_valid_o === 1'b1, {tag, " valid"}, int'(msg_valid_o), 1);
    chk(msg_op_o == 2'(op), {tag, " op"}, int'(msg_op_o), op);
    chk(msg_node_o == 2'(node), {tag, " node"}, int'(msg_node_o), node);
    chk(msg_blk_o == 2'(blk), {tag, " blk"}, int'(msg_blk_o), blk);
  endtask

  task automatic run_req(input int op, input int node, input int blk, input bit late, input bit hold);
    logic [3:0] oh, tgts;
    int mop;
    string tag;
    oh = 4'(1) << node;
    tgts = '0;
    mop = 1;
    if (op < 2 && st_m[blk] == 2) begin
      tgts = sh_m[blk] & ~oh; mop = (op == 0) ? 2 : 3;
    end else if (op == 1 && st_m[blk] == 1) begin
      tgts = sh_m[blk] & ~oh; mop = 1;
    end
    tag = (mop == 1) ? "R3" : (mop == 2) ? "R4" : "R5";
    @(negedge clk_i);
    chk(req_ready_o === 1'b1, "R8 ready before request", int'(req_ready_o), 1);
    req_valid_i = 1'b1; req_op_i = 2'(op); req_node_i = 2'(node); req_blk_i = 2'(blk);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (op == 2) begin
      chk(msg_valid_o === 1'b0, "R6 no message on writeback", int'(msg_valid_o), 0);
      if (st_m[blk] == 2 && sh_m[blk][node]) begin st_m[blk] = 0; sh_m[blk] = '0; end
      return;
    end
    for (int n = 0; n < 4; n++) begin
      if (tgts[n]) begin
        expect_msg(mop, n, blk, tag);
        if (!late) ack_valid_i = 1'b1;  // ack lands with the handshake (R7)
        @(negedge clk_i);
        ack_valid_i = 1'b0;
      end
    end
    if (late && tgts != '0) begin
      for (int k = 0; k < 3; k++) begin
        chk(msg_valid_o === 1'b0, "R7 no reply before acks", int'(msg_valid_o), 0);
        chk(req_ready_o === 1'b0, "R8 stalled while acks pending", int'(req_ready_o), 0);
        @(negedge clk_i);
      end
      for (int n = 0; n < 4; n++) begin
        if (tgts[n]) begin ack_valid_i = 1'b1; @(negedge clk_i); ack_valid_i = 1'b0; end
      end
    end
    wait_msg();
    if (hold) begin
      msg_ready_i = 1'b0;
      @(negedge clk_i);
      @(negedge clk_i);
      chk(msg_valid_o === 1'b1 && msg_op_o == 2'd0, "R9 reply held", int'(msg_valid_o), 1);
      msg_ready_i = 1'b1;
    end
    expect_msg(0, node, blk, (op == 0) ? "R1" : "R2");
    @(negedge clk_i);
    chk(msg_valid_o === 1'b0, "R1 single reply", int'(msg_valid_o), 0);
    if (op == 0) begin sh_m[blk] = sh_m[blk] | oh; st_m[blk] = 1; end
    else begin sh_m[blk] = oh; st_m[blk] = 2; end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++) begin st_m[b] = 0; sh_m[b] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11
    chk(req_ready_o === 1'b1, "R11 ready after reset", int'(req_ready_o), 1);
    chk(msg_valid_o === 1'b0, "R11 idle after reset", int'(msg_valid_o), 0);
    // directed walk on block 0
    run_req(0, 0, 0, 0, 0);  // R1 uncached read
    run_req(0, 2, 0, 0, 1);  // R1 shared read
    run_req(1, 0, 0, 1, 0);  // R3, R10: INV to node 2 only, late acks
    run_req(1, 1, 0, 0, 0);  // R5 FETCH_INV to node 0
    run_req(0, 3, 0, 0, 0);  // R4 FETCH to node 1
    run_req(2, 1, 0, 0, 0);  // R6 writeback on shared: ignored
    run_req(1, 3, 0, 1, 0);  // R3 INV to node 1
    run_req(2, 2, 0, 0, 0);  // R6 non-owner writeback ignored
    run_req(0, 0, 0, 0, 0);  // R4 FETCH to node 3 proves entry kept
    run_req(1, 3, 0, 0, 0);  // R3 INV to node 0
    run_req(2, 3, 0, 0, 0);  // R6 owner writeback
    run_req(1, 2, 0, 0, 0);  // R2 uncached write, no INV
    run_req(1, 2, 0, 0, 1);  // R10 owner rewrite: reply only
    run_req(0, 2, 0, 0, 0);  // R10 owner read: reply only
    run_req(1, 2, 0, 0, 0);  // R10 sole reader write: reply only
    // mixed sweep over all blocks, nodes and ops
    for (int i = 0; i < 600; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      run_req(int'(seed[22:16]) % 3, int'(seed[25:24]), int'(seed[27:26]),
              seed[29], seed[30] & seed[31]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule